// File: doc/BRIEF.md
# Interrupt Line Aggregator and Device Register Address Decoder

This block gathers level interrupt requests from five device classes, each holding up to eight devices, and reduces them to one interrupt line per class. Each clock it registers which devices are present and which of those are asking for service. Every class thus gets an eight-bit installed word and an eight-bit pending word. A class line is the OR of its pending word, so the line stays high until the last device on it has been acknowledged and has dropped its request. A priority picker names the most urgent pending line and the lowest-numbered pending device on that line. Class lines carry numbers 3 to 7, and the lower number is the more urgent.

Software reads a class's two bitmap words through a combinational read port addressed by line number. A second combinational path maps a byte address in the device register area to a line, a device and a register word. The area starts at 0x10000050, each line spans 0x80 bytes and each device spans 0x10 bytes. A third path builds a device's register base address from a line and a device number.

Top module: `irq_line_agg`

## Requirements
- R1: While rst_n is low, irq_line, irq_any, irq_top_line, irq_top_dev, rd_installed and rd_pending are all zero, whatever drives dev_present and dev_req.
- R2: Device n of class k sits at bit k*8+n of dev_present and dev_req, and class k is line 3+k. One clock after an edge, bit n of the installed word of line 3+k equals dev_present[k*8+n] as sampled at that edge.
- R3: One clock after an edge, the pending bit of a device equals its dev_req AND its dev_present as sampled at that edge, so a device that is not installed never shows as pending.
- R4: irq_line[k] is high exactly while the pending word of line 3+k is nonzero. With two devices pending, dropping one request keeps the line high. Dropping the last one clears it one clock later.
- R5: For rd_line from 3 to 7, rd_ok is 1 and rd_installed and rd_pending give that line's words. For any other rd_line value, all three are zero.
- R6: irq_any is 1 when any class line is high. irq_top_line is then the lowest-numbered high line and irq_top_dev is the lowest pending device number on it. With no line high, all three are 0.
- R7: For addr_i from 0x10000050 to 0x100002CF, dec_hit is 1. With off = addr_i − 0x10000050, the outputs are dec_line = 3 + off/128, dec_dev = (off mod 128)/16 and dec_word = (off mod 16)/4.
- R8: For any addr_i outside that range, dec_hit, dec_line, dec_dev and dec_word are all 0.
- R9: For gen_line from 3 to 7, gen_ok is 1 and gen_addr = 0x10000050 + (gen_line − 3) × 0x80 + gen_dev × 0x10. For any other gen_line value, gen_ok and gen_addr are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_present | input | 40 | Presence flag per device, bit k*8+n for device n of class k |
| dev_req | input | 40 | Level interrupt request per device, same bit layout |
| irq_line | output | 5 | Class interrupt lines, bit k is line 3+k |
| irq_any | output | 1 | Some class line is high |
| irq_top_line | output | 3 | Most urgent high line number |
| irq_top_dev | output | 3 | Lowest pending device on that line |
| rd_line | input | 3 | Line number selected for bitmap read |
| rd_ok | output | 1 | rd_line names a device class line |
| rd_installed | output | 8 | Installed word of the selected line |
| rd_pending | output | 8 | Pending word of the selected line |
| addr_i | input | 32 | Byte address to decode |
| dec_hit | output | 1 | Address falls inside the device register area |
| dec_line | output | 3 | Decoded line number |
| dec_dev | output | 3 | Decoded device number |
| dec_word | output | 2 | Decoded register word within the device |
| gen_line | input | 3 | Line number for base address generation |
| gen_dev | input | 3 | Device number for base address generation |
| gen_ok | output | 1 | gen_line names a device class line |
| gen_addr | output | 32 | Register base address of the named device |

## Verification
The bench builds the block with its default parameters: five classes of eight devices, a base of 0x10000050 and a 0x10-byte device stride. With these values the full 0x280-byte register area and both of its edge addresses can be reached, and every line number from 0 to 7 can be driven into the read and generation ports. Random presence and request patterns are mixed with directed cases. The directed cases cover a request from an absent device, an acknowledge that leaves a second device pending on the same line, and two lines pending together to test priority. The bench draws addresses both inside and around the area to cover each decode field and the miss boundaries.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Byte address of a device register block from a line offset and device index.
  function automatic logic [63:0] dev_block_addr(
    input logic [63:0] area_base,
    input int unsigned line_rel,
    input int unsigned dev_idx,
    input int unsigned dev_stride,
    input int unsigned devs_per_line
  );
    logic [63:0] line_part;
    logic [63:0] dev_part;
    line_part = 64'(line_rel) * 64'(devs_per_line) * 64'(dev_stride);
    dev_part  = 64'(dev_idx) * 64'(dev_stride);
    return area_base + line_part + dev_part;
  endfunction

  // True when a line number names one of the device class lines.
  function automatic logic is_class_line(
    input int unsigned line_no,
    input int unsigned first_line,
    input int unsigned n_classes
  );
    return (line_no >= first_line) && (line_no < first_line + n_classes);
  endfunction

endpackage

// File: rtl/irq_bitmap_bank.sv
module irq_bitmap_bank #(
  parameter int NUM_CLASSES = 5,
  parameter int DEVS        = 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_CLASSES-1:0][DEVS-1:0]  present_i,
  input  logic [NUM_CLASSES-1:0][DEVS-1:0]  req_i,
  output logic [NUM_CLASSES-1:0][DEVS-1:0]  inst_q,
  output logic [NUM_CLASSES-1:0][DEVS-1:0]  pend_q,
  output logic [NUM_CLASSES-1:0]            line_o
);

  logic armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_class
    logic [DEVS-1:0] masked_req;
    assign masked_req = req_i[k] & present_i[k];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        inst_q[k] <= '0;
        pend_q[k] <= '0;
      end else begin
        inst_q[k] <= present_i[k];
        pend_q[k] <= masked_req;
      end
    end

    assign line_o[k] = |pend_q[k];

    // R4
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      armed_q |-> (line_o[k] == $past(|(req_i[k] & present_i[k]))));
  end

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int NUM_CLASSES = 5,
  parameter int DEVS        = 8,
  parameter int FIRST_LINE  = 3,
  parameter int LINE_W      = 3,
  parameter int DEV_W       = 3
) (
  input  logic [NUM_CLASSES-1:0]            line_i,
  input  logic [NUM_CLASSES-1:0][DEVS-1:0]  pend_i,
  output logic                              any_o,
  output logic [LINE_W-1:0]                 top_line_o,
  output logic [DEV_W-1:0]                  top_dev_o
);

  always_comb begin
    any_o      = 1'b0;
    top_line_o = '0;
    top_dev_o  = '0;
    for (int k = NUM_CLASSES - 1; k >= 0; k--) begin
      if (line_i[k]) begin
        any_o      = 1'b1;
        top_line_o = LINE_W'(FIRST_LINE + k);
        for (int j = DEVS - 1; j >= 0; j--) begin
          if (pend_i[k][j]) top_dev_o = DEV_W'(j);
        end
      end
    end
  end

endmodule

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
  import irq_agg_pkg::*;
#(
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] AREA_BASE   = 32'h1000_0050,
  parameter int          NUM_CLASSES = 5,
  parameter int          DEVS        = 8,
  parameter int          DEV_STRIDE  = 16,
  parameter int          FIRST_LINE  = 3,
  parameter int          LINE_W      = 3,
  parameter int          DEV_W       = 3,
  parameter int          WORD_W      = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [LINE_W-1:0] line_o,
  output logic [DEV_W-1:0]  dev_o,
  output logic [WORD_W-1:0] word_o,
  input  logic [LINE_W-1:0] gen_line_i,
  input  logic [DEV_W-1:0]  gen_dev_i,
  output logic              gen_ok_o,
  output logic [ADDR_W-1:0] gen_addr_o
);

  localparam int LINE_STRIDE = DEVS * DEV_STRIDE;
  localparam int AREA_BYTES  = NUM_CLASSES * LINE_STRIDE;
  localparam int DEV_SH      = $clog2(DEV_STRIDE);
  localparam int LINE_SH     = $clog2(LINE_STRIDE);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-1:0] line_full;
  logic [ADDR_W-1:0] dev_full;
  logic [ADDR_W-1:0] word_full;
  logic [ADDR_W-1:0] rt_gap;

  always_comb begin
    off       = addr_i - ADDR_W'(AREA_BASE);
    hit_o     = (addr_i >= ADDR_W'(AREA_BASE)) && (off < ADDR_W'(AREA_BYTES));
    line_full = ADDR_W'(FIRST_LINE) + (off >> LINE_SH);
    dev_full  = off >> DEV_SH;
    word_full = off >> 2;
    line_o    = hit_o ? line_full[LINE_W-1:0] : '0;
    dev_o     = hit_o ? dev_full[DEV_W-1:0]   : '0;
    word_o    = hit_o ? word_full[WORD_W-1:0] : '0;
  end

  always_comb begin
    gen_ok_o   = is_class_line(int'(gen_line_i), FIRST_LINE, NUM_CLASSES);
    gen_addr_o = '0;
    if (gen_ok_o)
      gen_addr_o = ADDR_W'(dev_block_addr(64'(AREA_BASE),
                                          int'(gen_line_i) - FIRST_LINE,
                                          int'(gen_dev_i), DEV_STRIDE, DEVS));
  end

  // Distance from the block base rebuilt out of the decoded fields.
  always_comb begin
    rt_gap = addr_i
           - ADDR_W'(dev_block_addr(64'(AREA_BASE), int'(line_o) - FIRST_LINE,
                                    int'(dev_o), DEV_STRIDE, DEVS))
           - (ADDR_W'(word_o) << 2);
  end

  // R7
  decode_roundtrip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |-> (rt_gap < ADDR_W'(4)));

  // R8
  decode_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> ((line_o == '0) && (dev_o == '0) && (word_o == '0)));

endmodule

// File: rtl/irq_line_agg.sv
module irq_line_agg
  import irq_agg_pkg::*;
#(
  parameter int          NUM_CLASSES = 5,
  parameter int          DEVS        = 8,
  parameter int          FIRST_LINE  = 3,
  parameter int          ADDR_W      = 32,
  parameter logic [31:0] AREA_BASE   = 32'h1000_0050,
  parameter int          DEV_STRIDE  = 16,
  parameter int          TOTAL       = NUM_CLASSES * DEVS,
  parameter int          LINE_W      = $clog2(FIRST_LINE + NUM_CLASSES),
  parameter int          DEV_W       = $clog2(DEVS),
  parameter int          WORD_W      = $clog2(DEV_STRIDE / 4)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [TOTAL-1:0]       dev_present,
  input  logic [TOTAL-1:0]       dev_req,
  output logic [NUM_CLASSES-1:0] irq_line,
  output logic                   irq_any,
  output logic [LINE_W-1:0]      irq_top_line,
  output logic [DEV_W-1:0]       irq_top_dev,
  input  logic [LINE_W-1:0]      rd_line,
  output logic                   rd_ok,
  output logic [DEVS-1:0]        rd_installed,
  output logic [DEVS-1:0]        rd_pending,
  input  logic [ADDR_W-1:0]      addr_i,
  output logic                   dec_hit,
  output logic [LINE_W-1:0]      dec_line,
  output logic [DEV_W-1:0]       dec_dev,
  output logic [WORD_W-1:0]      dec_word,
  input  logic [LINE_W-1:0]      gen_line,
  input  logic [DEV_W-1:0]       gen_dev,
  output logic                   gen_ok,
  output logic [ADDR_W-1:0]      gen_addr
);

  logic [NUM_CLASSES-1:0][DEVS-1:0] present_w;
  logic [NUM_CLASSES-1:0][DEVS-1:0] req_w;
  logic [NUM_CLASSES-1:0][DEVS-1:0] inst_w;
  logic [NUM_CLASSES-1:0][DEVS-1:0] pend_w;

  assign present_w = dev_present;
  assign req_w     = dev_req;

  irq_bitmap_bank #(.NUM_CLASSES(NUM_CLASSES), .DEVS(DEVS)) bank_i (
    .clk(clk), .rst_n(rst_n),
    .present_i(present_w), .req_i(req_w),
    .inst_q(inst_w), .pend_q(pend_w), .line_o(irq_line)
  );

  irq_prio_pick #(
    .NUM_CLASSES(NUM_CLASSES), .DEVS(DEVS), .FIRST_LINE(FIRST_LINE),
    .LINE_W(LINE_W), .DEV_W(DEV_W)
  ) pick_i (
    .line_i(irq_line), .pend_i(pend_w),
    .any_o(irq_any), .top_line_o(irq_top_line), .top_dev_o(irq_top_dev)
  );

  irq_addr_decode #(
    .ADDR_W(ADDR_W), .AREA_BASE(AREA_BASE), .NUM_CLASSES(NUM_CLASSES),
    .DEVS(DEVS), .DEV_STRIDE(DEV_STRIDE), .FIRST_LINE(FIRST_LINE),
    .LINE_W(LINE_W), .DEV_W(DEV_W), .WORD_W(WORD_W)
  ) dec_i (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i),
    .hit_o(dec_hit), .line_o(dec_line), .dev_o(dec_dev), .word_o(dec_word),
    .gen_line_i(gen_line), .gen_dev_i(gen_dev),
    .gen_ok_o(gen_ok), .gen_addr_o(gen_addr)
  );

  // Bitmap read port
  always_comb begin
    rd_ok        = is_class_line(int'(rd_line), FIRST_LINE, NUM_CLASSES);
    rd_installed = '0;
    rd_pending   = '0;
    for (int k = 0; k < NUM_CLASSES; k++) begin
      if (rd_ok && (int'(rd_line) == FIRST_LINE + k)) begin
        rd_installed = inst_w[k];
        rd_pending   = pend_w[k];
      end
    end
  end

  // R3
  pend_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pending & ~rd_installed) == '0);

  // R6
  prio_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_any |-> (irq_line == '0));

  for (genvar k = 0; k < NUM_CLASSES; k++) begin : g_prio_chk
    // R6
    prio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_any && (int'(irq_top_line) == FIRST_LINE + k)) |->
        (irq_line[k] && ((irq_line & NUM_CLASSES'((1 << k) - 1)) == '0)));
  end

endmodule

// File: tb/irq_line_agg_tb_top.sv
`timescale 1ns/1ps
module irq_line_agg_tb_top;

  localparam int NC = 5;
  localparam int ND = 8;
  localparam int NT = NC * ND;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] dev_present = '0;
  logic [NT-1:0] dev_req = '0;
  logic [NC-1:0] irq_line;
  logic          irq_any;
  logic [2:0]    irq_top_line;
  logic [2:0]    irq_top_dev;
  logic [2:0]    rd_line = 3'd3;
  logic          rd_ok;
  logic [7:0]    rd_installed;
  logic [7:0]    rd_pending;
  logic [31:0]   addr_i = '0;
  logic          dec_hit;
  logic [2:0]    dec_line;
  logic [2:0]    dec_dev;
  logic [1:0]    dec_word;
  logic [2:0]    gen_line = '0;
  logic [2:0]    gen_dev = '0;
  logic          gen_ok;
  logic [31:0]   gen_addr;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  irq_line_agg dut_i (
    .clk(clk), .rst_n(rst_n), .dev_present(dev_present), .dev_req(dev_req),
    .irq_line(irq_line), .irq_any(irq_any), .irq_top_line(irq_top_line),
    .irq_top_dev(irq_top_dev), .rd_line(rd_line), .rd_ok(rd_ok),
    .rd_installed(rd_installed), .rd_pending(rd_pending), .addr_i(addr_i),
    .dec_hit(dec_hit), .dec_line(dec_line), .dec_dev(dec_dev),
    .dec_word(dec_word), .gen_line(gen_line), .gen_dev(gen_dev),
    .gen_ok(gen_ok), .gen_addr(gen_addr)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected models
  function automatic logic [7:0] cls_word(input logic [NT-1:0] v, input int k);
    logic [7:0] w;
    for (int n = 0; n < ND; n++) w[n] = v[k*ND + n];
    return w;
  endfunction

  function automatic logic [NC-1:0] exp_lines(input logic [NT-1:0] p, input logic [NT-1:0] r);
    logic [NC-1:0] l;
    for (int k = 0; k < NC; k++) l[k] = (cls_word(p, k) & cls_word(r, k)) != 8'h00;
    return l;
  endfunction

  // Drive at a falling edge, check the registered view at the next falling edge.
  task automatic step_check(input logic [NT-1:0] p, input logic [NT-1:0] r, input logic [2:0] rl);
    logic [NC-1:0] el;
    int top_k;
    int top_d;
    dev_present = p; dev_req = r; rd_line = rl;
    @(negedge clk);
    el = exp_lines(p, r);
    chk(irq_line == el, "R4 irq_line", longint'(irq_line), longint'(el));
    top_k = -1; top_d = 0;
    for (int k = NC - 1; k >= 0; k--) if (el[k]) top_k = k;
    if (top_k >= 0) begin
      for (int d = ND - 1; d >= 0; d--) if (p[top_k*ND+d] && r[top_k*ND+d]) top_d = d;
      chk(irq_any && irq_top_line == 3'(top_k + 3) && irq_top_dev == 3'(top_d),
          "R6 top", longint'({irq_any, irq_top_line, irq_top_dev}),
          longint'({1'b1, 3'(top_k + 3), 3'(top_d)}));
    end else begin
      chk(!irq_any && irq_top_line == 0 && irq_top_dev == 0, "R6 idle",
          longint'({irq_any, irq_top_line, irq_top_dev}), 0);
    end
    if (rl >= 3) begin
      chk(rd_ok && rd_installed == cls_word(p, rl - 3), "R2 installed",
          longint'(rd_installed), longint'(cls_word(p, rl - 3)));
      chk(rd_pending == (cls_word(p, rl - 3) & cls_word(r, rl - 3)), "R3 pending",
          longint'(rd_pending), longint'(cls_word(p, rl - 3) & cls_word(r, rl - 3)));
    end else begin
      chk(!rd_ok && rd_installed == 0 && rd_pending == 0, "R5 bad line",
          longint'({rd_ok, rd_installed, rd_pending}), 0);
    end
  endtask

  task automatic dec_check(input logic [31:0] a);
    longint off;
    bit eh;
    logic [2:0] el, ed;
    logic [1:0] ew;
    addr_i = a;
    #1;
    off = longint'(a) - 64'h1000_0050;
    eh = (off >= 0) && (off < 640);
    el = eh ? 3'(3 + off / 128) : 3'd0;
    ed = eh ? 3'((off % 128) / 16) : 3'd0;
    ew = eh ? 2'((off % 16) / 4) : 2'd0;
    chk({dec_hit, dec_line, dec_dev, dec_word} == {eh, el, ed, ew},
        eh ? "R7 decode" : "R8 miss",
        longint'({dec_hit, dec_line, dec_dev, dec_word}), longint'({eh, el, ed, ew}));
  endtask

  task automatic gen_check(input logic [2:0] l, input logic [2:0] d);
    bit eo;
    logic [31:0] ea;
    gen_line = l; gen_dev = d;
    #1;
    eo = (l >= 3);
    ea = eo ? 32'h1000_0050 + 32'(int'(l) - 3) * 32'd128 + 32'(d) * 32'd16 : 32'd0;
    chk(gen_ok == eo && gen_addr == ea, "R9 gen", longint'({gen_ok, gen_addr}), longint'({eo, ea}));
  endtask

  function automatic logic [NT-1:0] rnd_vec();
    return {$urandom(), $urandom()} >> (64 - NT);
  endfunction

  initial begin
    logic [NT-1:0] p;
    void'($urandom(32'd20240611));
    // R1: reset holds everything low while inputs are busy
    dev_present = '1; dev_req = '1; rd_line = 3'd5;
    repeat (3) @(negedge clk);
    chk(irq_line == 0 && !irq_any && irq_top_line == 0 && irq_top_dev == 0,
        "R1 lines", longint'({irq_line, irq_any, irq_top_line, irq_top_dev}), 0);
    chk(rd_installed == 0 && rd_pending == 0, "R1 bitmaps",
        longint'({rd_installed, rd_pending}), 0);
    rst_n = 1'b1;

    // R3: request from an absent device is masked
    step_check(40'h0, 40'h00_0000_0001, 3'd3);
    step_check(40'h00_0000_00FE, 40'h00_0000_0001, 3'd3);
    // R4: two pending on line 4, acknowledge one, then the other
    step_check(40'h00_0000_2400, 40'h00_0000_2400, 3'd4);
    step_check(40'h00_0000_2400, 40'h00_0000_2000, 3'd4);
    step_check(40'h00_0000_2400, 40'h00_0000_0000, 3'd4);
    // R6: lines 7 and 5 both pending, line 5 wins with its lowest device
    step_check(40'hFF_00FF_0000, 40'h80_0030_0000, 3'd7);
    step_check(40'hFF_00FF_0000, 40'h80_0000_0000, 3'd7);
    // R5: every non-class line number
    for (int l = 0; l < 3; l++) step_check(40'hFF_FFFF_FFFF, 40'hFF_FFFF_FFFF, 3'(l));

    // Random bitmaps
    for (int i = 0; i < 400; i++) begin
      p = rnd_vec();
      step_check(p, rnd_vec(), 3'($urandom_range(0, 7)));
    end

    // R7 / R8 corners then random addresses
    dec_check(32'h1000_004F);
    dec_check(32'h1000_0050);
    dec_check(32'h1000_02CF);
    dec_check(32'h1000_02D0);
    dec_check(32'h0000_0000);
    dec_check(32'hFFFF_FFFF);
    dec_check(32'h1000_00D3);
    for (int i = 0; i < 300; i++) begin
      if (i % 2 == 0) dec_check(32'h1000_0000 + 32'($urandom_range(0, 32'h300)));
      else            dec_check($urandom());
    end

    // R9 every line and device
    for (int l = 0; l < 8; l++)
      for (int d = 0; d < 8; d++) gen_check(3'(l), 3'(d));

    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule